// File: doc/BRIEF.md
# Trigger Frame Merging Output Formatter

This block packs pixel readout data into framed packets for the serial output link. Each accepted level-1 trigger is queued with its event number. When the block is idle and a trigger is waiting, it opens a frame with a header word and then passes that trigger's payload words through from the readout pipeline. The end of each trigger's payload is marked by a last-word flag on the input. After that word, a trailer word closes the frame and carries the number of payload words in the frame.

A trigger may be recorded while a frame is still being sent, up to the moment the current payload segment's last word is accepted. Such a trigger does not get a frame of its own and is not lost. The open frame is stretched instead: a second header is placed directly after the last word of the segment in progress, and the payload for the new trigger follows it. A single trailer then closes the combined frame, and its count covers every payload word in the frame. Pending triggers wait in a four-entry queue. A trigger that finds the queue full is discarded, and a sticky flag records the loss.

Both the payload input and the word output use a valid/ready handshake. Payload words are only taken when the output can accept them. Reset is synchronous and active high.

Top module: `frame_merge_fmt`

## Requirements
- R1: While reset is high, and on the cycle after it, outValid, payReady and overflow are all low, and no frame is open.
- R2: A header word is {4'hA, 12'h000, event[15:0]}. Each frame opens with the header of the oldest queued trigger. That trigger's payload words then follow unchanged and in order.
- R3: A trailer word is {4'hF, 12'h000, count[15:0]}. The count is the number of payload words output since the previous trailer. outLast is high on the trailer and on no other word.
- R4: Suppose a trigger is queued before the last payload word (payLast high) of the current segment is accepted. The next word is then a header for that trigger instead of a trailer. The frame carries one trailer in total, and its count covers the payload of every merged trigger.
- R5: If the queue is empty when a segment's last payload word is accepted, the frame is closed by a trailer. A trigger that arrives later opens a new frame, whose count starts from zero.
- R6: Payload segments are consumed in the order in which their triggers were queued. Each segment ends on the word presented with payLast high.
- R7: The queue holds up to 4 triggers that have not yet had their header output. A trigger that arrives while 4 are held is dropped, with no header ever output for it. overflow goes high on the next cycle and stays high until reset.
- R8: While outValid is high and outReady is low, outData and outValid hold their values and payReady stays low.
- R9: payReady is high only in a frame's payload phase. Payload offered while idle or during a header or trailer is not consumed.
- R10: A reset asserted in the middle of a frame abandons that frame. The next trigger after reset produces a complete new frame whose trailer counts only its own words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigValid | input | 1 | Level-1 trigger strobe, one trigger per high cycle |
| trigEvent | input | 16 | Event number of the trigger |
| payValid | input | 1 | Payload word valid |
| payData | input | 32 | Payload word |
| payLast | input | 1 | Marks the final payload word of the current trigger |
| payReady | output | 1 | Payload word accepted when high together with payValid |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Output word: header, payload or trailer |
| outLast | output | 1 | High on the trailer word that closes a frame |
| outReady | input | 1 | Downstream accepts the output word |
| overflow | output | 1 | Sticky flag: a trigger was dropped because the queue was full |

## Verification
The hardest state to reach is a trigger that lands while a frame is in progress, before its current segment has finished. The bench gets there by stretching the segment with a stuttering outReady and issuing the second trigger a few cycles into the payload. That trigger is then sure to be queued before the final word is accepted. A full queue is produced by holding outReady low, so that the first header cannot leave, and firing five triggers back to back. Releasing the output afterwards then yields one frame carrying four headers. A mid-frame reset followed by a fresh trigger shows that no partial count survives.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_TRL
  } fmtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selHdr;
    logic selPay;
    logic selTrl;
    logic popTrig;
    logic cntInc;
    logic cntClear;
  } ctrlStrobe_t;

  localparam int unsigned TAG_W   = 4;
  localparam logic [3:0]  HDR_TAG = 4'hA;
  localparam logic [3:0]  TRL_TAG = 4'hF;

endpackage

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill;
  logic             doPush, doPop;

  assign full   = (fill == CNT_W'(DEPTH));
  assign empty  = (fill == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      fill <= fill + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fifoEmpty,
  input  logic        payValid,
  input  logic        payLast,
  input  logic        outReady,
  output ctrlStrobe_t strobe
);

  fmtState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (!fifoEmpty) stateNext = ST_HDR;
      end
      ST_HDR: begin
        strobe.selHdr = 1'b1;
        if (outReady) begin
          strobe.popTrig = 1'b1;
          stateNext      = ST_PAY;
        end
      end
      ST_PAY: begin
        strobe.selPay = 1'b1;
        if (payValid && outReady) begin
          strobe.cntInc = 1'b1;
          // segment done: merge a pending trigger or close the frame
          if (payLast) stateNext = fifoEmpty ? ST_TRL : ST_HDR;
        end
      end
      ST_TRL: begin
        strobe.selTrl = 1'b1;
        if (outReady) begin
          strobe.cntClear = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/frame_dp.sv
module frame_dp
  import fmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [EVT_W-1:0]  evtHead,
  input  logic              payValid,
  input  logic [DATA_W-1:0] payData,
  input  logic              outReady,
  input  logic              dropStrobe,
  output logic              payReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              overflow
);

  localparam int unsigned HPAD_W = DATA_W - TAG_W - EVT_W;
  localparam int unsigned TPAD_W = DATA_W - TAG_W - CNT_W;

  logic [CNT_W-1:0]  wordCnt;
  logic [DATA_W-1:0] hdrWord, trlWord;

  assign hdrWord = {HDR_TAG, {HPAD_W{1'b0}}, evtHead};
  assign trlWord = {TRL_TAG, {TPAD_W{1'b0}}, wordCnt};

  always_comb begin
    outData = '0;
    if (strobe.selHdr)      outData = hdrWord;
    else if (strobe.selTrl) outData = trlWord;
    else if (strobe.selPay) outData = payData;
  end

  assign outValid = strobe.selHdr || strobe.selTrl || (strobe.selPay && payValid);
  assign outLast  = strobe.selTrl;
  assign payReady = strobe.selPay && outReady;

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) wordCnt <= '0;
    else if (strobe.cntInc)     wordCnt <= wordCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             overflow <= 1'b0;
    else if (dropStrobe) overflow <= 1'b1;
  end

endmodule

// File: rtl/frame_merge_fmt.sv
module frame_merge_fmt
  import fmt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned EVT_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TRIG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigValid,
  input  logic [EVT_W-1:0]  trigEvent,
  input  logic              payValid,
  input  logic [DATA_W-1:0] payData,
  input  logic              payLast,
  output logic              payReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  input  logic              outReady,
  output logic              overflow
);

  ctrlStrobe_t      strobe;
  logic             fifoEmpty, trigFull;
  logic [EVT_W-1:0] evtHead;

  trig_fifo #(.DEPTH(TRIG_DEPTH), .WIDTH(EVT_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (trigValid),
    .din   (trigEvent),
    .pop   (strobe.popTrig),
    .dout  (evtHead),
    .empty (fifoEmpty),
    .full  (trigFull)
  );

  frame_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fifoEmpty (fifoEmpty),
    .payValid  (payValid),
    .payLast   (payLast),
    .outReady  (outReady),
    .strobe    (strobe)
  );

  frame_dp #(.DATA_W(DATA_W), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .evtHead    (evtHead),
    .payValid   (payValid),
    .payData    (payData),
    .outReady   (outReady),
    .dropStrobe (trigValid && trigFull),
    .payReady   (payReady),
    .outValid   (outValid),
    .outData    (outData),
    .outLast    (outLast),
    .overflow   (overflow)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              trigValid,
  input logic              trigFull,
  input logic              payValid,
  input logic              payReady,
  input logic [DATA_W-1:0] payData,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outLast,
  input logic              overflow
);

  logic [CNT_W-1:0] seenPay;

  always_ff @(posedge clk) begin
    if (rst || (outValid && outReady && outLast)) seenPay <= '0;
    else if (payValid && payReady)                seenPay <= seenPay + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!outValid && !payReady && !overflow));

  a_r3_trailer_tag: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast) |-> (outData[DATA_W-1 -: 4] == 4'hF));

  a_r3_trailer_count: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast) |-> (outData[CNT_W-1:0] == seenPay));

  a_r7_drop_flag: assert property (@(posedge clk) disable iff (rst)
    (trigValid && trigFull) |=> overflow);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r8_no_read: assert property (@(posedge clk) disable iff (rst)
    !outReady |-> !payReady);

  a_r9_passthru: assert property (@(posedge clk) disable iff (rst)
    (payValid && payReady) |-> (outValid && !outLast && outData == payData));

endmodule

bind frame_merge_fmt fmt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trigValid (trigValid),
  .trigFull  (trigFull),
  .payValid  (payValid),
  .payReady  (payReady),
  .payData   (payData),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .outLast   (outLast),
  .overflow  (overflow)
);

// File: tb/frame_merge_fmt_test.sv
module frame_merge_fmt_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trigValid = 1'b0;
  logic [15:0] trigEvent = '0;
  logic        payValid = 1'b0;
  logic [31:0] payData = '0;
  logic        payLast = 1'b0;
  logic        payReady;
  logic        outValid;
  logic [31:0] outData;
  logic        outLast;
  logic        outReady = 1'b1;
  logic        overflow;

  frame_merge_fmt uut (
    .clk(clk), .rst(rst), .trigValid(trigValid), .trigEvent(trigEvent),
    .payValid(payValid), .payData(payData), .payLast(payLast), .payReady(payReady),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outReady(outReady),
    .overflow(overflow)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  // payload source state
  int segLen [0:7];
  int numSeg   = 0;
  int segIdx   = 0;
  int wordIdx  = 0;
  int dataCtr  = 0;
  bit payGo    = 0;
  bit payFire  = 0;
  int readyMode = 0;
  int readyCyc  = 0;

  // recorded and expected output
  logic [31:0] recWord [0:63];
  logic        recLast [0:63];
  int          recCnt = 0;
  logic [31:0] expWord [0:63];
  logic        expLast [0:63];
  int          expCnt = 0;
  int          expData = 0;

  // sample away from the active edge
  always @(negedge clk) begin
    payFire = payValid && payReady && !rst;
    if (!rst && outValid && outReady && recCnt < 64) begin
      recWord[recCnt] = outData;
      recLast[recCnt] = outLast;
      recCnt++;
    end
  end

  // payload and ready drivers, just after the edge
  always @(posedge clk) begin
    #1;
    if (payFire) begin
      payFire = 0;
      dataCtr++;
      if (wordIdx == segLen[segIdx] - 1) begin
        wordIdx = 0;
        segIdx++;
      end else begin
        wordIdx++;
      end
    end
    payValid = payGo && (segIdx < numSeg);
    payData  = 32'h5000_0000 + 32'(dataCtr);
    payLast  = (segIdx < numSeg) && (wordIdx == segLen[segIdx] - 1);
    readyCyc++;
    outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (readyCyc % 3 != 0) : 1'b0;
  end

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    printSummary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk);
    #2;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) sync();
  endtask

  task automatic pulseTrig(input logic [15:0] ev);
    sync();
    trigValid = 1'b1;
    trigEvent = ev;
    sync();
    trigValid = 1'b0;
  endtask

  task automatic startScenario();
    sync();
    payGo = 0;
    numSeg = 0;
    segIdx = 0;
    wordIdx = 0;
    dataCtr = 0;
    readyMode = 0;
    sync();
    recCnt = 0;
    expCnt = 0;
    expData = 0;
  endtask

  task automatic expHdr(input logic [15:0] ev);
    expWord[expCnt] = {4'hA, 12'h000, ev};
    expLast[expCnt] = 1'b0;
    expCnt++;
  endtask

  task automatic expPay(input int n);
    for (int i = 0; i < n; i++) begin
      expWord[expCnt] = 32'h5000_0000 + 32'(expData);
      expLast[expCnt] = 1'b0;
      expData++;
      expCnt++;
    end
  endtask

  task automatic expTrl(input int n);
    expWord[expCnt] = {4'hF, 12'h000, 16'(n)};
    expLast[expCnt] = 1'b1;
    expCnt++;
  endtask

  task automatic compareStream(input string req);
    for (int t = 0; t < 2000 && recCnt < expCnt; t++) sync();
    cycles(6);
    check(recCnt == expCnt, {req, " word count"}, 32'(recCnt), 32'(expCnt));
    for (int i = 0; i < expCnt && i < recCnt; i++) begin
      check(recWord[i] == expWord[i], {req, " word"}, recWord[i], expWord[i]);
      check(recLast[i] == expLast[i], {req, " outLast"}, 32'(recLast[i]), 32'(expLast[i]));
    end
  endtask

  // R1: state during and after reset
  task automatic testReset();
    sync();
    rst = 1'b1;
    cycles(3);
    check(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 0);
    check(payReady == 1'b0, "R1 payReady in reset", 32'(payReady), 0);
    rst = 1'b0;
    sync();
    check(outValid == 1'b0, "R1 outValid after reset", 32'(outValid), 0);
    check(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 0);
  endtask

  // R9: payload offered while idle is not consumed
  task automatic testIdlePayload();
    startScenario();
    segLen[0] = 2;
    numSeg = 1;
    payGo = 1;
    cycles(6);
    check(payReady == 1'b0, "R9 payReady while idle", 32'(payReady), 0);
    check(dataCtr == 0, "R9 no payload consumed while idle", 32'(dataCtr), 0);
    check(recCnt == 0, "R9 no output while idle", 32'(recCnt), 0);
    pulseTrig(16'h0011);
    expHdr(16'h0011); expPay(2); expTrl(2);
    compareStream("R9 frame after idle payload");
  endtask

  // R2 R3: one trigger, one frame
  task automatic testSingle();
    startScenario();
    segLen[0] = 3;
    numSeg = 1;
    payGo = 1;
    pulseTrig(16'hBEEF);
    expHdr(16'hBEEF); expPay(3); expTrl(3);
    compareStream("R2 R3 single frame");
  endtask

  // R4 R8: second trigger during a stalled payload merges into the frame
  task automatic testMergeStall();
    startScenario();
    segLen[0] = 6;
    segLen[1] = 3;
    numSeg = 2;
    payGo = 1;
    readyMode = 1;
    pulseTrig(16'h0101);
    cycles(4);
    pulseTrig(16'h0202);
    expHdr(16'h0101); expPay(6); expHdr(16'h0202); expPay(3); expTrl(9);
    compareStream("R4 R8 merged frame under back-pressure");
  endtask

  // R5 R6: trigger after the trailer opens a separate frame
  task automatic testSeparate();
    startScenario();
    segLen[0] = 2;
    segLen[1] = 3;
    numSeg = 2;
    payGo = 1;
    pulseTrig(16'h0A0A);
    for (int t = 0; t < 200 && recCnt < 4; t++) sync();
    cycles(4);
    pulseTrig(16'h0B0B);
    expHdr(16'h0A0A); expPay(2); expTrl(2);
    expHdr(16'h0B0B); expPay(3); expTrl(3);
    compareStream("R5 R6 two separate frames");
  endtask

  // R7 R4: full queue, fifth trigger dropped, four headers in one frame
  task automatic testOverflow();
    startScenario();
    readyMode = 2;
    for (int k = 1; k <= 4; k++) pulseTrig(16'(k));
    sync();
    check(overflow == 1'b0, "R7 no overflow with 4 queued", 32'(overflow), 0);
    pulseTrig(16'h0005);
    sync();
    check(overflow == 1'b1, "R7 overflow on fifth trigger", 32'(overflow), 1);
    for (int k = 0; k < 4; k++) segLen[k] = 1 + k;
    numSeg = 4;
    payGo = 1;
    readyMode = 0;
    for (int k = 1; k <= 4; k++) begin
      expHdr(16'(k));
      expPay(k);
    end
    expTrl(10);
    compareStream("R7 R4 four merged triggers, fifth dropped");
    check(overflow == 1'b1, "R7 overflow sticky", 32'(overflow), 1);
  endtask

  // R10: reset mid-frame, then a clean frame
  task automatic testMidReset();
    startScenario();
    segLen[0] = 8;
    numSeg = 1;
    payGo = 1;
    readyMode = 1;
    pulseTrig(16'h0C0C);
    cycles(6);
    rst = 1'b1;
    payGo = 0;
    sync();
    rst = 1'b0;
    sync();
    check(outValid == 1'b0, "R10 idle after mid-frame reset", 32'(outValid), 0);
    check(overflow == 1'b0, "R1 R10 overflow cleared by reset", 32'(overflow), 0);
    startScenario();
    segLen[0] = 2;
    numSeg = 1;
    payGo = 1;
    pulseTrig(16'h0D0D);
    expHdr(16'h0D0D); expPay(2); expTrl(2);
    compareStream("R10 fresh frame after reset");
  endtask

  initial begin
    testReset();
    testIdlePayload();
    testSingle();
    testMergeStall();
    testSeparate();
    testOverflow();
    testMidReset();
    printSummary();
    $finish;
  end

endmodule